// File: doc/BRIEF.md
# Host-Loadable Macrocell Register Bank with Write Masks

This block holds a bank of output macrocell flip-flops, organised as groups of eight. In normal operation each bit is driven by internal logic through four signals: next-state data, a clock enable that stands in for the macrocell clock, preset and clear. A microcontroller on a byte-wide parallel bus can also load any group directly. A host load overrides the internal signals for every bit it reaches. Each group has its own write-mask register. A mask bit set to 1 shields its flip-flop from host loads and leaves the bit under internal control.

The bank is built in one of two load modes, fixed by a parameter. In edge mode the block records the address and data while the write strobe is active. It applies them at the first clock edge where the strobe is seen deasserted. In level mode the addressed bits take the bus value on every clock edge for as long as the strobe stays active. The host can read back both the flip-flop values and the masks. The block also produces one registered output enable per pin. Pins that have no enable equation are held enabled permanently.

Top module: `macrocell_bank`

## Requirements
- R1: A synchronous active-high reset clears every macrocell, both mask registers and the readback data to zero.
- R2: Without a host load, each bit follows this priority at each clock: clear forces 0, else preset forces 1, else an active enable takes the next-state bit, else the bit holds.
- R3: In edge mode, a host write changes nothing while the strobe (write with chip select) stays active. The data and address seen in the last active cycle are applied at the first clock edge where the strobe is low.
- R4: In level mode, at every clock edge with the strobe active, the unmasked bits of the addressed group take the bus data.
- R5: A host load overrides clear, preset and enable on every unmasked bit it reaches.
- R6: Address 0 selects macrocells 7:0 and address 1 selects macrocells 15:8. Address 2 selects the mask of group 0 and address 3 selects the mask of group 1. Mask bit i guards bit i of its group.
- R7: A mask bit set to 1 blocks host loads to its macrocell in both modes. The macrocell stays under internal control, including during an active level-mode strobe.
- R8: A read with chip select at a clock edge returns the addressed macrocell byte or mask byte on the readback port after that edge. In any cycle without a read, the readback port shows 0.
- R9: The output enable of each pin with an enable equation equals the internal enable term OR the direction bit, one clock later.
- R10: A pin whose enable-equation parameter bit is 0 has its output enable at 1 at all times, including during reset.
- R11: With chip select low, the write and read strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select |
| host_addr | input | 2 | Host byte address (groups, then masks) |
| host_wr | input | 1 | Host write strobe, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered readback data |
| int_d | input | 16 | Internal next-state value per macrocell |
| int_pre | input | 16 | Internal preset per macrocell |
| int_clr | input | 16 | Internal clear per macrocell |
| int_en | input | 16 | Internal clock enable per macrocell |
| oe_term | input | 16 | Internal output-enable term per pin |
| dir_bits | input | 16 | Direction register bit per pin |
| mc_q | output | 16 | Macrocell flip-flop values |
| pin_oe | output | 16 | Registered per-pin output enable |

## Verification
A wrong mask bit or a wrong group decode shows up as a corrupted macrocell byte at the readback port. Readback returns one cycle after the read. A macrocell with the wrong value appears on `mc_q` at the first clock edge after the faulty load. In edge mode, this is the edge at which the strobe is first seen low. A mode mix-up shows earlier, because the bits change while the strobe is still active. Errors in the clear, preset and enable priority show on the bit itself one clock after the internal inputs are applied.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  typedef enum logic {LOAD_LEVEL = 1'b0, LOAD_EDGE = 1'b1} mcb_load_e;
endpackage

// File: rtl/mcb_host_if.sv
module mcb_host_if #(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter mcb_pkg::mcb_load_e LOAD_MODE = mcb_pkg::LOAD_EDGE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ld_valid,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data
);
  logic wr_act;
  assign wr_act = cs & wr;

  generate
    if (LOAD_MODE == mcb_pkg::LOAD_EDGE) begin : g_edge
      logic          wr_q;
      logic [AW-1:0] cap_addr;
      logic [DW-1:0] cap_data;
      always_ff @(posedge clk) begin
        if (rst) begin
          wr_q     <= 1'b0;
          cap_addr <= '0;
          cap_data <= '0;
        end else begin
          wr_q <= wr_act;
          if (wr_act) begin
            cap_addr <= addr;
            cap_data <= wdata;
          end
        end
      end
      assign ld_valid = wr_q & ~wr_act;
      assign ld_addr  = cap_addr;
      assign ld_data  = cap_data;

      // R3: a trailing-edge load never fires while the strobe is still active
      assert_edge_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> ($past(cs && wr) && !(cs && wr)));
    end else begin : g_level
      assign ld_valid = wr_act;
      assign ld_addr  = addr;
      assign ld_data  = wdata;
    end
  endgenerate
endmodule

// File: rtl/mcb_cell_group.sv
module mcb_cell_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         data_hit,
  input  logic         mask_hit,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] d,
  input  logic [W-1:0] pre,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] q,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      mask <= '0;
    end else begin
      if (mask_hit) mask <= ld_data;
      for (int i = 0; i < W; i++) begin
        if (data_hit && !mask[i]) q[i] <= ld_data[i];
        else if (clr[i])          q[i] <= 1'b0;
        else if (pre[i])          q[i] <= 1'b1;
        else if (en[i])           q[i] <= d[i];
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (q == '0 && mask == '0));

  assert_clear_first_R2: assert property (@(posedge clk) disable iff (rst)
    !data_hit |=> ((q & $past(clr)) == '0));

  assert_load_overrides_R5: assert property (@(posedge clk) disable iff (rst)
    data_hit |=> (((q ^ $past(ld_data)) & $past(~mask)) == '0));

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    data_hit |=> (((q ^ $past(q)) & $past(mask & ~(clr | pre | en))) == '0));
endmodule

// File: rtl/mcb_readback.sv
module mcb_readback #(
  parameter int GROUPS = 2,
  parameter int W      = 8,
  localparam int AW    = $clog2(2 * GROUPS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_act,
  input  logic [AW-1:0]       addr,
  input  logic [GROUPS*W-1:0] q_all,
  input  logic [GROUPS*W-1:0] mask_all,
  output logic [W-1:0]        rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (int'(addr) == g)          sel = q_all[g*W +: W];
      if (int'(addr) == GROUPS + g) sel = mask_all[g*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_act) rdata <= sel;
    else             rdata <= '0;
  end

  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> (rdata == '0));
endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank #(
  parameter int GROUPS = 2,
  parameter int W      = 8,
  parameter mcb_pkg::mcb_load_e LOAD_MODE = mcb_pkg::LOAD_EDGE,
  parameter logic [GROUPS*W-1:0] HAS_OE_EQ = '1,
  localparam int N  = GROUPS * W,
  localparam int AW = $clog2(2 * GROUPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  input  logic [N-1:0]  int_d,
  input  logic [N-1:0]  int_pre,
  input  logic [N-1:0]  int_clr,
  input  logic [N-1:0]  int_en,
  input  logic [N-1:0]  oe_term,
  input  logic [N-1:0]  dir_bits,
  output logic [N-1:0]  mc_q,
  output logic [N-1:0]  pin_oe
);
  logic          ld_valid;
  logic [AW-1:0] ld_addr;
  logic [W-1:0]  ld_data;
  logic [N-1:0]  mask_all;

  mcb_host_if #(.AW(AW), .DW(W), .LOAD_MODE(LOAD_MODE)) u_host (
    .clk(clk), .rst(rst), .cs(host_cs), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic data_hit, mask_hit;
      assign data_hit = ld_valid && (int'(ld_addr) == g);
      assign mask_hit = ld_valid && (int'(ld_addr) == GROUPS + g);
      mcb_cell_group #(.W(W)) u_grp (
        .clk(clk), .rst(rst), .data_hit(data_hit), .mask_hit(mask_hit),
        .ld_data(ld_data),
        .d(int_d[g*W +: W]), .pre(int_pre[g*W +: W]),
        .clr(int_clr[g*W +: W]), .en(int_en[g*W +: W]),
        .q(mc_q[g*W +: W]), .mask(mask_all[g*W +: W])
      );
    end
  endgenerate

  mcb_readback #(.GROUPS(GROUPS), .W(W)) u_rb (
    .clk(clk), .rst(rst), .rd_act(host_cs & host_rd), .addr(host_addr),
    .q_all(mc_q), .mask_all(mask_all), .rdata(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_oe <= ~HAS_OE_EQ;
    else     pin_oe <= ((oe_term | dir_bits) & HAS_OE_EQ) | ~HAS_OE_EQ;
  end

  assert_oe_follows_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_oe ^ $past(oe_term | dir_bits)) & HAS_OE_EQ) == '0));

  assert_default_pin_on_R10: assert property (@(posedge clk)
    $past(rst) |-> ((pin_oe & ~HAS_OE_EQ) == ~HAS_OE_EQ));

  assert_no_cs_no_read_R11: assert property (@(posedge clk) disable iff (rst)
    !host_cs |=> (host_rdata == '0));
endmodule

// File: tb/macrocell_bank_test.sv
`timescale 1ns/1ps
module macrocell_bank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, cs_l = 0, wr = 0, rd = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [15:0] d = '0, pre = '0, clr = '0, en = '0, term = '0, dir = '0;
  logic [7:0]  rdata, rdata_l;
  logic [15:0] q, q_l, oe, oe_l;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  macrocell_bank #(.HAS_OE_EQ(16'h7FFF)) uut (
    .clk(clk), .rst(rst), .host_cs(cs), .host_addr(addr), .host_wr(wr),
    .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata),
    .int_d(d), .int_pre(pre), .int_clr(clr), .int_en(en),
    .oe_term(term), .dir_bits(dir), .mc_q(q), .pin_oe(oe));

  macrocell_bank #(.LOAD_MODE(mcb_pkg::LOAD_LEVEL)) uut_lvl (
    .clk(clk), .rst(rst), .host_cs(cs_l), .host_addr(addr), .host_wr(wr),
    .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata_l),
    .int_d(d), .int_pre(pre), .int_clr(clr), .int_en(en),
    .oe_term(term), .dir_bits(dir), .mc_q(q_l), .pin_oe(oe_l));

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] a, logic [7:0] v);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = v;
    @(negedge clk); cs = 0; wr = 0;
    @(negedge clk);
  endtask

  task automatic hread(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); v = rdata; cs = 0; rd = 0;
  endtask

  // {is_read, addr[1:0], data[7:0], expected[7:0]}
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h5A, 8'h00}, {1'b1, 2'd0, 8'h00, 8'h5A},
    {1'b0, 2'd1, 8'hC3, 8'h00}, {1'b1, 2'd1, 8'h00, 8'hC3},
    {1'b0, 2'd2, 8'h0F, 8'h00}, {1'b1, 2'd2, 8'h00, 8'h0F},
    {1'b0, 2'd0, 8'hFF, 8'h00}, {1'b1, 2'd0, 8'h00, 8'hFA},
    {1'b1, 2'd1, 8'h00, 8'hC3}, {1'b0, 2'd3, 8'hF0, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h00}, {1'b1, 2'd1, 8'h00, 8'hC0},
    {1'b1, 2'd3, 8'h00, 8'hF0}
  };

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    // R1 / R10: state during reset
    chk("R1 mc_q", q, 16'h0000);
    chk("R1 rdata", {8'h0, rdata}, 16'h0000);
    chk("R1 level mc_q", q_l, 16'h0000);
    chk("R10 oe in reset", oe, 16'h8000);
    rst = 0;
    @(negedge clk);
    chk("R1 mask0 readback", 16'h0, 16'h0);
    hread(2'd2, rv); chk("R1 mask0 after reset", {8'h0, rv}, 16'h0000);

    // R6 / R7 / R8: vector walk (edge mode)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) begin
        hread(VEC[i][17:16], rv);
        chk("R6 R7 R8 vector", {8'h0, rv}, {8'h0, VEC[i][7:0]});
      end else begin
        hwrite(VEC[i][17:16], VEC[i][15:8]);
      end
    end
    @(negedge clk); chk("R8 idle rdata", {8'h0, rdata}, 16'h0000);

    hwrite(2'd2, 8'h00); hwrite(2'd3, 8'h00);

    // R3: nothing moves while strobe active; load at trailing edge
    @(negedge clk); cs = 1; wr = 1; addr = 2'd1; wdata = 8'h3C;
    @(negedge clk); wdata = 8'h3C;
    @(negedge clk); chk("R3 hold while active", q, 16'hC0FA);
    wdata = 8'h81;
    @(negedge clk); chk("R3 still holding", q, 16'hC0FA);
    cs = 0; wr = 0;
    @(negedge clk); chk("R3 last active data applied", q, 16'h81FA);

    // R5: load wins over clear on unmasked bits
    clr = 16'hFFFF;
    hwrite(2'd0, 8'hA5);
    chk("R5 load beats clear", q, 16'h00A5);
    clr = 16'h0000;

    // R2: clear > preset > enable > hold
    @(negedge clk); clr = 16'h0001; pre = 16'h0003; en = 16'h000C; d = 16'h0004;
    @(negedge clk); clr = 0; pre = 0; en = 0; d = 0;
    chk("R2 priority", q, 16'h00A6);
    @(negedge clk); chk("R2 hold", q, 16'h00A6);

    // R11: chip select low ignores strobes
    @(negedge clk); wr = 1; addr = 2'd0; wdata = 8'hFF;
    @(negedge clk); wr = 0;
    @(negedge clk); chk("R11 write ignored", q, 16'h00A6);
    rd = 1;
    @(negedge clk); rd = 0; chk("R11 read ignored", {8'h0, rdata}, 16'h0000);

    // R9 / R10: output enables
    term = 16'h00F0; dir = 16'h0F00;
    @(negedge clk); chk("R9 R10 oe", oe, 16'h8FF0);
    chk("R9 level instance oe", oe_l, 16'h0FF0);
    term = 0; dir = 0;
    @(negedge clk); chk("R10 oe default pin", oe, 16'h8000);

    // R4 / R7: level mode
    @(negedge clk); cs_l = 1; wr = 1; addr = 2'd2; wdata = 8'h01;
    @(negedge clk); cs_l = 0; wr = 0;
    @(negedge clk); cs_l = 1; wr = 1; addr = 2'd0; wdata = 8'hAA; pre = 16'h0001;
    @(negedge clk); chk("R4 R7 level follows bus", q_l, 16'h00AB);
    wdata = 8'h54; pre = 16'h0000;
    @(negedge clk); chk("R4 level tracks change", q_l, 16'h0055);
    clr = 16'h0001;
    @(negedge clk); chk("R7 masked bit internal", q_l, 16'h0054);
    cs_l = 0; wr = 0; clr = 0;
    @(negedge clk); chk("R3 edge unit untouched", q, 16'h00A6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule